// File: doc/BRIEF.md
# Common Interface Card Access Bridge

This block lets a host reach two conditional-access card slots through a small set of byte-wide registers. The host writes a 14-bit card address into two address registers. It picks the slot and the address space (attribute memory, or control/I-O) in a bus control register. It then reads or writes the data register. That single data-register access runs a complete card bus cycle with setup, strobe and hold phases, and a read returns the card's byte. A card that stretches the cycle through its wait line is honoured up to a bounded timeout.

The same bus control register starts a timed reset pulse on either slot. Its request bit stays set until the pulse and a settle interval have passed, and then clears by itself. It also enables stream routing through each slot and reports debounced card-detect levels. A second control register enables the two stream outputs and drives the active-low reset lines of the two front ends. Any debounced card-detect change raises an interrupt, and a host read of the interrupt register clears it.

The host port is a single-cycle request with an acknowledge. Register accesses are acknowledged on the next cycle. A data-register access is acknowledged once the card cycle has finished, and a data request that arrives while a card cycle is running is dropped.

Top module: `ci_bridge`

## Requirements
- R1: The card address driven during a cycle is {reg 0x05 bits 6:0, reg 0x04 bits 7:1}. Reg 0x04 reads back with bit 0 as 0, and reg 0x05 reads back with bit 7 as 0. Both reset to 0.
- R2: Bus control (reg 0x07) bit 7 selects the slot: 0 drives card_sel_n = 2'b10 and 1 drives 2'b01 during a cycle. Bit 6 is driven on card_ctl_space, where 1 means control/I-O space and 0 means attribute memory. At most one select is active at any time.
- R3: A host read of reg 0x06 runs one card cycle that pulses only card_rd_n and returns card_din in host_rdata with host_ack. A host write of reg 0x06 runs one cycle that pulses only card_wr_n, with host_wdata on card_dout.
- R4: In each card cycle, the select is active for SETUP_CYC cycles before the strobe. The strobe lasts STROBE_CYC cycles when card_wait_n is high. The select stays active for HOLD_CYC cycles after the strobe ends.
- R5: If card_wait_n is low when the strobe would end, the strobe is extended until card_wait_n is sampled high. After WAIT_LIMIT extra cycles the cycle ends, and a read then returns 8'hFF.
- R6: Writing 1 to bus control bit 5 (slot 0) or bit 4 (slot 1) drives card_rst for that slot high for RST_HOLD_CYC cycles. The bit then reads 1 until a further RST_SETTLE_CYC cycles have passed, and then reads 0 without any host action. The other slot is not affected.
- R7: Bus control bit 3 drives ts_route_en[0] and bit 2 drives ts_route_en[1]. Both read back.
- R8: Bus control bit 1 (slot 0) and bit 0 (slot 1) show the debounced card_det_n level, where 0 means a card is present. Both read 1 after reset. A level held for fewer than DEBOUNCE_CYC cycles does not change them.
- R9: In reg 0x01, bit 4 drives ts_out_en[0], bit 5 drives ts_out_en[1], bit 3 drives fe_rst_n[0] and bit 2 drives fe_rst_n[1]. The other bits read 0, and the register resets to 8'h0C.
- R10: A debounced card-detect change on either slot raises irq. A host read of reg 0x00 returns bit 0 = 1 while irq is raised, and irq is low on the following cycle.
- R11: After reset, bus control reads 8'h03, irq is low, no select, strobe or slot reset is active, and ts_route_en and ts_out_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | One-cycle register access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_ack | output | 1 | Access complete |
| card_addr | output | 14 | Card address |
| card_ctl_space | output | 1 | 1 = control/I-O space, 0 = attribute memory |
| card_sel_n | output | 2 | Slot selects, active low |
| card_rd_n | output | 1 | Read strobe, active low |
| card_wr_n | output | 1 | Write strobe, active low |
| card_dout | output | 8 | Data to card |
| card_dout_en | output | 1 | Drive enable for card_dout |
| card_din | input | 8 | Data from card |
| card_wait_n | input | 1 | Card wait, active low |
| card_rst | output | 2 | Slot reset pulses, active high |
| card_det_n | input | 2 | Raw card detect, active low |
| ts_route_en | output | 2 | Stream routing through each slot |
| ts_out_en | output | 2 | Stream output enables |
| fe_rst_n | output | 2 | Front-end resets, active low |
| irq | output | 1 | Card-detect change interrupt |

## Verification
A wrong address latch or slot decode shows on card_addr, card_sel_n and card_ctl_space from the first strobe cycle of the access. It also corrupts the returned byte, because the bench card model derives that byte from exactly those pins. A phase counter that is off by one changes the measured setup, strobe or hold width within that same cycle. A wait or timeout fault shows as a wrong strobe length or a missing 8'hFF. A stuck reset or debounce state shows as a request bit that never clears, or as a status bit or irq that moves on a short glitch or fails to move within a few dozen cycles of a held level.

// File: rtl/ci_bridge_pkg.sv
// Shared types and register map for the card access bridge.
// Assumes byte-wide host registers addressed by a 4-bit offset.
package ci_bridge_pkg;

    localparam logic [3:0] REG_IRQ    = 4'h0;
    localparam logic [3:0] REG_CTRL2  = 4'h1;
    localparam logic [3:0] REG_ADDR_L = 4'h4;
    localparam logic [3:0] REG_ADDR_H = 4'h5;
    localparam logic [3:0] REG_DATA   = 4'h6;
    localparam logic [3:0] REG_BUS    = 4'h7;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_SETUP,
        CYC_STROBE,
        CYC_WAIT,
        CYC_HOLD
    } cyc_state_t;

    typedef enum logic [1:0] {
        RST_IDLE,
        RST_ASSERT,
        RST_SETTLE
    } rst_phase_t;

endpackage

// File: rtl/ci_card_cycle.sv
// Card bus cycle engine: runs one setup/strobe/hold cycle per start pulse.
// Latches address, slot, space and write data at start. Extends the strobe
// while the card holds wait low, up to WAIT_LIMIT cycles, and then returns
// all ones on a read. Assumes every phase count is at least 1.
module ci_card_cycle
    import ci_bridge_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2,
    parameter int WAIT_LIMIT = 250,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic              slot,
    input  logic              space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] card_addr,
    output logic              card_ctl_space,
    output logic [1:0]        card_sel_n,
    output logic              card_rd_n,
    output logic              card_wr_n,
    output logic [DATA_W-1:0] card_dout,
    output logic              card_dout_en,
    input  logic [DATA_W-1:0] card_din,
    input  logic              card_wait_n
);
    localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_CD = (HOLD_CYC > WAIT_LIMIT) ? HOLD_CYC : WAIT_LIMIT;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);
    localparam int RW     = $clog2(STROBE_CYC + WAIT_LIMIT + 2);

    cyc_state_t        state;
    logic [CW-1:0]     cnt;
    logic              we_q, slot_q, space_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              strobe;

    // Phase sequencing, request latching and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CYC_IDLE;
            cnt     <= '0;
            we_q    <= 1'b0;
            slot_q  <= 1'b0;
            space_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                CYC_IDLE: if (start) begin
                    state   <= CYC_SETUP;
                    cnt     <= CW'(SETUP_CYC - 1);
                    we_q    <= we;
                    slot_q  <= slot;
                    space_q <= space;
                    addr_q  <= addr;
                    wdata_q <= wdata;
                end
                CYC_SETUP: if (cnt == '0) begin
                    state <= CYC_STROBE;
                    cnt   <= CW'(STROBE_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CYC_STROBE: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (card_wait_n) begin
                    rdata <= card_din;
                    state <= CYC_HOLD;
                    cnt   <= CW'(HOLD_CYC - 1);
                end else begin
                    state <= CYC_WAIT;
                    cnt   <= CW'(WAIT_LIMIT - 1);
                end
                CYC_WAIT: if (card_wait_n) begin
                    rdata <= card_din;
                    state <= CYC_HOLD;
                    cnt   <= CW'(HOLD_CYC - 1);
                end else if (cnt == '0) begin
                    rdata <= '1;
                    state <= CYC_HOLD;
                    cnt   <= CW'(HOLD_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CYC_HOLD: if (cnt == '0) begin
                    state <= CYC_IDLE;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    // Card pin decode from the current phase.
    always_comb begin
        busy           = (state != CYC_IDLE);
        strobe         = (state == CYC_STROBE) || (state == CYC_WAIT);
        card_sel_n     = busy ? ~(2'b01 << slot_q) : 2'b11;
        card_rd_n      = !(strobe && !we_q);
        card_wr_n      = !(strobe && we_q);
        card_addr      = addr_q;
        card_ctl_space = space_q;
        card_dout      = wdata_q;
        card_dout_en   = busy && we_q;
    end

    // Length of the current strobe run, kept for the wait bound check.
    logic [RW-1:0] strobe_run;
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_run <= '0;
        else        strobe_run <= (!card_rd_n || !card_wr_n) ? strobe_run + 1'b1 : '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!card_rd_n && !card_wr_n)); // R3
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~card_sel_n) <= 1); // R2
    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_rd_n || !card_wr_n) |-> (card_sel_n != 2'b11)); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(card_addr)); // R1
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_rd_n || !card_wr_n) |-> (strobe_run < RW'(STROBE_CYC + WAIT_LIMIT))); // R5
endmodule

// File: rtl/ci_slot_reset.sv
// Per-slot reset pulse: holds the reset active for HOLD_CYC cycles, then
// stays busy for SETTLE_CYC cycles before reporting completion.
// Start requests while busy are ignored. Assumes both counts are >= 1.
module ci_slot_reset
    import ci_bridge_pkg::*;
#(
    parameter int HOLD_CYC   = 25000,
    parameter int SETTLE_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic rst_out
);
    localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    rst_phase_t    phase;
    logic [CW-1:0] cnt;

    // Pulse then settle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= RST_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                RST_IDLE: if (start) begin
                    phase <= RST_ASSERT;
                    cnt   <= CW'(HOLD_CYC - 1);
                end
                RST_ASSERT: if (cnt == '0) begin
                    phase <= RST_SETTLE;
                    cnt   <= CW'(SETTLE_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                RST_SETTLE: if (cnt == '0) phase <= RST_IDLE;
                            else           cnt   <= cnt - 1'b1;
                default: phase <= RST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy    = (phase != RST_IDLE);
        rst_out = (phase == RST_ASSERT);
    end

    AST_SETTLE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> busy); // R6
    AST_PULSE_STARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> !$past(busy)); // R6
endmodule

// File: rtl/ci_det_filter.sv
// Card-detect filter: synchronises the raw active-low detect input and
// accepts a new level only after it has held for FILTER_CYC cycles. Pulses
// changed for one cycle when the accepted level moves. The level resets to 1.
module ci_det_filter #(
    parameter int FILTER_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic level,
    output logic changed
);
    localparam int CW = $clog2(FILTER_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser and agreement counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            level   <= 1'b1;
            cnt     <= '0;
            changed <= 1'b0;
        end else begin
            sync_q  <= {sync_q[0], raw_n};
            changed <= 1'b0;
            if (sync_q[1] == level) begin
                cnt <= '0;
            end else if (cnt == CW'(FILTER_CYC - 1)) begin
                level   <= sync_q[1];
                cnt     <= '0;
                changed <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (level == $past(sync_q[1]))); // R8
    AST_CHANGE_MARKS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> !$stable(level)); // R8
endmodule

// File: rtl/ci_bridge.sv
// Card access bridge top: host register file, card cycle engine, per-slot
// reset pulses and card-detect filters with an interrupt.
// Assumes the host waits for host_ack before its next data-register access.
module ci_bridge
    import ci_bridge_pkg::*;
#(
    parameter int SETUP_CYC      = 2,
    parameter int STROBE_CYC     = 4,
    parameter int HOLD_CYC       = 2,
    parameter int WAIT_LIMIT     = 250,
    parameter int RST_HOLD_CYC   = 25000,
    parameter int RST_SETTLE_CYC = 250000,
    parameter int DEBOUNCE_CYC   = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_ack,
    output logic [13:0] card_addr,
    output logic        card_ctl_space,
    output logic [1:0]  card_sel_n,
    output logic        card_rd_n,
    output logic        card_wr_n,
    output logic [7:0]  card_dout,
    output logic        card_dout_en,
    input  logic [7:0]  card_din,
    input  logic        card_wait_n,
    output logic [1:0]  card_rst,
    input  logic [1:0]  card_det_n,
    output logic [1:0]  ts_route_en,
    output logic [1:0]  ts_out_en,
    output logic [1:0]  fe_rst_n,
    output logic        irq
);
    localparam int NSLOT  = 2;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;

    logic [6:0]       addr_lo, addr_hi;
    logic             slot_sel, space_sel;
    logic             irq_pend;
    logic             cyc_busy, cyc_done, cyc_we_q;
    logic [DATA_W-1:0] cyc_rdata;
    logic [NSLOT-1:0] rst_busy, det_level, det_change;
    logic             wr_bus, rd_irq, cyc_start, reg_acc;
    logic [7:0]       bus_rd, rd_mux;

    // Host request decode.
    always_comb begin
        wr_bus    = host_req && host_we && (host_addr == REG_BUS);
        rd_irq    = host_req && !host_we && (host_addr == REG_IRQ);
        cyc_start = host_req && (host_addr == REG_DATA) && !cyc_busy;
        reg_acc   = host_req && (host_addr != REG_DATA);
    end

    // Writable register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo     <= '0;
            addr_hi     <= '0;
            slot_sel    <= 1'b0;
            space_sel   <= 1'b0;
            ts_route_en <= '0;
            ts_out_en   <= '0;
            fe_rst_n    <= 2'b11;
            cyc_we_q    <= 1'b0;
        end else begin
            if (cyc_start) cyc_we_q <= host_we;
            if (host_req && host_we) begin
                case (host_addr)
                    REG_ADDR_L: addr_lo <= host_wdata[7:1];
                    REG_ADDR_H: addr_hi <= host_wdata[6:0];
                    REG_CTRL2: begin
                        ts_out_en <= host_wdata[5:4];
                        fe_rst_n  <= {host_wdata[2], host_wdata[3]};
                    end
                    REG_BUS: begin
                        slot_sel    <= host_wdata[7];
                        space_sel   <= host_wdata[6];
                        ts_route_en <= {host_wdata[2], host_wdata[3]};
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-slot reset pulse and detect filter; slot i uses bus bits 5-i, 3-i, 1-i.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        ci_slot_reset #(
            .HOLD_CYC  (RST_HOLD_CYC),
            .SETTLE_CYC(RST_SETTLE_CYC)
        ) u_rst (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (wr_bus && host_wdata[5-i]),
            .busy   (rst_busy[i]),
            .rst_out(card_rst[i])
        );
        ci_det_filter #(
            .FILTER_CYC(DEBOUNCE_CYC)
        ) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_n  (card_det_n[i]),
            .level  (det_level[i]),
            .changed(det_change[i])
        );
    end

    // Card cycle engine.
    ci_card_cycle #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAIT_LIMIT(WAIT_LIMIT),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_cyc (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (cyc_start),
        .we            (host_we),
        .slot          (slot_sel),
        .space         (space_sel),
        .addr          ({addr_hi, addr_lo}),
        .wdata         (host_wdata),
        .busy          (cyc_busy),
        .done          (cyc_done),
        .rdata         (cyc_rdata),
        .card_addr     (card_addr),
        .card_ctl_space(card_ctl_space),
        .card_sel_n    (card_sel_n),
        .card_rd_n     (card_rd_n),
        .card_wr_n     (card_wr_n),
        .card_dout     (card_dout),
        .card_dout_en  (card_dout_en),
        .card_din      (card_din),
        .card_wait_n   (card_wait_n)
    );

    // Read-back multiplexer.
    always_comb begin
        bus_rd = {slot_sel, space_sel, 6'b0};
        for (int i = 0; i < NSLOT; i++) begin
            bus_rd[5-i] = rst_busy[i];
            bus_rd[3-i] = ts_route_en[i];
            bus_rd[1-i] = det_level[i];
        end
        case (host_addr)
            REG_IRQ:    rd_mux = {7'b0, irq_pend};
            REG_CTRL2:  rd_mux = {2'b0, ts_out_en, fe_rst_n[0], fe_rst_n[1], 2'b0};
            REG_ADDR_L: rd_mux = {addr_lo, 1'b0};
            REG_ADDR_H: rd_mux = {1'b0, addr_hi};
            REG_BUS:    rd_mux = bus_rd;
            default:    rd_mux = 8'h00;
        endcase
    end

    // Interrupt pending: set by a filtered detect change, cleared by a read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)             irq_pend <= 1'b0;
        else if (|det_change)   irq_pend <= 1'b1;
        else if (rd_irq)        irq_pend <= 1'b0;
    end
    assign irq = irq_pend;

    // Host response: register accesses next cycle, data accesses at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= reg_acc || cyc_done;
            if (reg_acc && !host_we)  host_rdata <= rd_mux;
            if (cyc_done && !cyc_we_q) host_rdata <= cyc_rdata;
        end
    end

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|det_change) |=> irq); // R10
    AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_irq && !(|det_change)) |=> !irq); // R10
    AST_ACK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> host_ack); // R3
endmodule

// File: tb/tb_ci_bridge.sv
// Self-checking bench for ci_bridge with short phase, reset and filter counts.
module tb_ci_bridge;
    localparam int SU = 2, ST = 3, HO = 2, WL = 6, RH = 5, RS = 4, DB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic [13:0] card_addr;
    logic        card_ctl_space;
    logic [1:0]  card_sel_n;
    logic        card_rd_n, card_wr_n;
    logic [7:0]  card_dout;
    logic        card_dout_en;
    logic [7:0]  card_din;
    logic        card_wait_n = 1'b1;
    logic [1:0]  card_rst;
    logic [1:0]  card_det_n = 2'b11;
    logic [1:0]  ts_route_en, ts_out_en, fe_rst_n;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    ci_bridge #(
        .SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO), .WAIT_LIMIT(WL),
        .RST_HOLD_CYC(RH), .RST_SETTLE_CYC(RS), .DEBOUNCE_CYC(DB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .card_addr(card_addr), .card_ctl_space(card_ctl_space),
        .card_sel_n(card_sel_n), .card_rd_n(card_rd_n), .card_wr_n(card_wr_n),
        .card_dout(card_dout), .card_dout_en(card_dout_en), .card_din(card_din),
        .card_wait_n(card_wait_n), .card_rst(card_rst), .card_det_n(card_det_n),
        .ts_route_en(ts_route_en), .ts_out_en(ts_out_en), .fe_rst_n(fe_rst_n),
        .irq(irq)
    );

    // Card model byte, a function of the pins the card sees.
    function automatic logic [7:0] card_byte(input logic [13:0] a, input logic s, input logic sp);
        return a[7:0] ^ {2'b00, a[13:8]} ^ (s ? 8'hA5 : 8'h00) ^ (sp ? 8'h3C : 8'h00);
    endfunction

    assign card_din = card_byte(card_addr, card_sel_n[0], card_ctl_space);

    // Bus monitor, sampled at the falling edge.
    int setup_n, strobe_n, hold_n, rst0_n, rst1_n, wait_extra;
    logic seen_strobe, rd_seen, wr_seen, obs_space;
    logic [13:0] obs_addr;
    logic [1:0]  obs_sel;
    logic [7:0]  obs_wd;

    task automatic mon_clear();
        setup_n = 0; strobe_n = 0; hold_n = 0; seen_strobe = 0;
        rd_seen = 0; wr_seen = 0; obs_addr = '0; obs_sel = 2'b11;
        obs_space = 0; obs_wd = '0;
    endtask

    always @(negedge clk) begin
        if (card_rst[0]) rst0_n++;
        if (card_rst[1]) rst1_n++;
        if (card_sel_n != 2'b11 && card_rd_n && card_wr_n) begin
            if (seen_strobe) hold_n++;
            else             setup_n++;
        end
        if (!card_rd_n || !card_wr_n) begin
            seen_strobe = 1;
            strobe_n++;
            obs_addr = card_addr; obs_sel = card_sel_n; obs_space = card_ctl_space;
            if (!card_rd_n) rd_seen = 1;
            if (!card_wr_n) begin wr_seen = 1; obs_wd = card_dout; end
            card_wait_n = (strobe_n < ST) ? 1'b1 : (strobe_n >= ST + wait_extra);
        end else begin
            card_wait_n = 1'b1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [3:0] a, input logic [7:0] wd,
                       output logic [7:0] rd);
        int guard;
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = a; host_wdata = wd;
        guard = 0;
        do begin
            @(negedge clk);
            host_req = 0;
            guard++;
        end while (!host_ack && guard < 200);
        rd = host_rdata;
    endtask

    task automatic set_addr(input logic [13:0] a);
        logic [7:0] d;
        acc(1, 4'h4, {a[6:0], 1'b0}, d);
        acc(1, 4'h5, {1'b0, a[13:7]}, d);
    endtask

    initial begin
        logic [7:0] d;
        logic [13:0] a;
        wait_extra = 0;
        mon_clear();
        rst0_n = 0; rst1_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        chk("R11 sel idle", {card_sel_n, card_rd_n, card_wr_n}, 4'hF);
        chk("R11 outputs", {irq, card_rst, ts_route_en, ts_out_en, fe_rst_n}, 9'h003);
        acc(0, 4'h7, 0, d); chk("R11 bus ctrl reset", d, 8'h03);
        acc(0, 4'h0, 0, d); chk("R11 irq reg reset", d, 8'h00);
        acc(0, 4'h1, 0, d); chk("R9 ctrl2 reset", d, 8'h0C);
        acc(0, 4'h4, 0, d); chk("R1 addr lo reset", d, 8'h00);

        // R1 register readback masks
        acc(1, 4'h4, 8'hFF, d); acc(0, 4'h4, 0, d); chk("R1 addr lo bit0", d, 8'hFE);
        acc(1, 4'h5, 8'hFF, d); acc(0, 4'h5, 0, d); chk("R1 addr hi bit7", d, 8'h7F);

        // R1 R2 R3 R4 R5 read sweep over slots, spaces and addresses
        for (int s = 0; s < 2; s++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int k = 0; k < 16; k++) begin
                    a = (k == 0) ? 14'h0000 : (k == 15) ? 14'h3FFF : (14'h0001 << (k - 1));
                    set_addr(a);
                    acc(1, 4'h7, {s[0], sp[0], 6'b0}, d);
                    wait_extra = k % 3;
                    mon_clear();
                    acc(0, 4'h6, 0, d);
                    chk("R3 read byte", d, card_byte(a, s[0], sp[0]));
                    chk("R1 card address", obs_addr, a);
                    chk("R2 select and space", {obs_sel, obs_space},
                        {(s != 0) ? 2'b01 : 2'b10, sp[0]});
                    chk("R4 R5 setup/strobe/hold", {setup_n[7:0], strobe_n[7:0], hold_n[7:0]},
                        {8'(SU), 8'(ST + wait_extra), 8'(HO)});
                    chk("R3 only read strobe", {rd_seen, wr_seen}, 2'b10);
                end
            end
        end

        // R5 longest accepted wait and timeout
        a = 14'h2A5C;
        set_addr(a);
        acc(1, 4'h7, 8'h00, d);
        wait_extra = WL; mon_clear(); acc(0, 4'h6, 0, d);
        chk("R5 wait at limit data", d, card_byte(a, 1'b0, 1'b0));
        chk("R5 wait at limit length", strobe_n, ST + WL);
        wait_extra = WL + 5; mon_clear(); acc(0, 4'h6, 0, d);
        chk("R5 timeout data", d, 8'hFF);
        chk("R5 timeout length", strobe_n, ST + WL);
        wait_extra = 0;

        // R3 writes on both slots
        for (int k = 0; k < 4; k++) begin
            a = (k % 2 == 0) ? 14'h1555 : 14'h2AAA;
            set_addr(a);
            acc(1, 4'h7, {k[1], k[0], 6'b0}, d);
            mon_clear();
            acc(1, 4'h6, 8'h5A ^ 8'(k), d);
            chk("R3 write data", obs_wd, 8'h5A ^ 8'(k));
            chk("R3 write address", obs_addr, a);
            chk("R2 write select", obs_sel, k[1] ? 2'b01 : 2'b10);
            chk("R3 only write strobe", {rd_seen, wr_seen}, 2'b01);
            chk("R4 write phases", {setup_n[7:0], strobe_n[7:0], hold_n[7:0]},
                {8'(SU), 8'(ST), 8'(HO)});
        end

        // R7 stream routing bits
        acc(1, 4'h7, 8'h08, d);
        chk("R7 route slot0", ts_route_en, 2'b01);
        acc(0, 4'h7, 0, d); chk("R7 route readback", d, 8'h0B);
        acc(1, 4'h7, 8'h04, d);
        chk("R7 route slot1", ts_route_en, 2'b10);

        // R9 second control register
        acc(1, 4'h1, 8'hFF, d); acc(0, 4'h1, 0, d);
        chk("R9 ctrl2 mask", d, 8'h3C);
        chk("R9 ctrl2 pins all", {ts_out_en, fe_rst_n}, 4'hF);
        acc(1, 4'h1, 8'h18, d); acc(0, 4'h1, 0, d);
        chk("R9 ctrl2 readback", d, 8'h18);
        chk("R9 ctrl2 pins split", {ts_out_en, fe_rst_n}, 4'b0101);

        // R6 slot 0 reset pulse and self-clearing bit
        rst0_n = 0; rst1_n = 0;
        acc(1, 4'h7, 8'h20, d);
        acc(0, 4'h7, 0, d); chk("R6 slot0 busy bit", d, 8'h23);
        repeat (RH + RS + 4) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R6 slot0 bit cleared", d, 8'h03);
        chk("R6 slot0 pulse width", rst0_n, RH);
        chk("R6 slot1 untouched", rst1_n, 0);
        // R6 slot 1
        rst0_n = 0; rst1_n = 0;
        acc(1, 4'h7, 8'h10, d);
        acc(0, 4'h7, 0, d); chk("R6 slot1 busy bit", d, 8'h13);
        repeat (RH + RS + 4) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R6 slot1 bit cleared", d, 8'h03);
        chk("R6 slot1 pulse width", {rst0_n[7:0], rst1_n[7:0]}, {8'd0, 8'(RH)});

        // R8 R10 card detect filter and interrupt
        card_det_n[1] = 1'b0;
        repeat (DB / 2) @(negedge clk);
        card_det_n[1] = 1'b1;
        repeat (DB + 6) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R8 glitch ignored", d[1:0], 2'b11);
        chk("R10 no irq on glitch", irq, 1'b0);
        card_det_n[0] = 1'b0;
        repeat (DB + 6) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R8 slot0 present", d[1:0], 2'b01);
        chk("R10 irq raised", irq, 1'b1);
        acc(0, 4'h0, 0, d); chk("R10 irq reg read", d, 8'h01);
        chk("R10 irq cleared", irq, 1'b0);
        acc(0, 4'h0, 0, d); chk("R10 irq reg after ack", d, 8'h00);
        card_det_n[1] = 1'b0;
        repeat (DB + 6) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R8 both present", d[1:0], 2'b00);
        chk("R10 irq slot1", irq, 1'b1);
        acc(0, 4'h0, 0, d);
        card_det_n = 2'b11;
        repeat (DB + 6) @(negedge clk);
        acc(0, 4'h7, 0, d); chk("R8 both removed", d[1:0], 2'b11);
        chk("R10 irq on removal", irq, 1'b1);

        summary();
        $finish;
    end
endmodule